// File: doc/BRIEF.md
# Transaction-Locked Command Stream Arbiter

This block lets two independent command-stream generators share one execution engine for a serial bus. Each generator connects to a slave-side port made of four valid/ready streams: command words going out, transmit data going out, receive data coming back and sync responses coming back. The engine connects to the single master-side port, which has the same four streams.

A fixed-priority arbiter picks the port that may drive the engine, and port 0 wins a tie. Once a port holds the grant, it keeps the master port for a whole transaction. The transaction ends when the port's SYNC command has been accepted and the engine has returned a sync response carrying the same identifier. While the grant is held, transmit data is forwarded only from the owner, and receive data and sync responses are steered only to the owner. The other port is held off on every stream.

A command is a 16-bit word. It is a SYNC when its upper four bits equal the `SYNC_OP` parameter (default 4'b0011). Its low eight bits are the sync identifier, which the engine echoes on the sync response stream.

Top module: `cmd_stream_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the grant is cleared. After that edge, `m_cmd_valid`, every slave command/transmit ready output, every slave receive/sync valid output, `m_rx_ready` and `m_sync_ready` are low.
- R2: With no grant, `m_cmd_valid` and both command ready outputs are low. A command valid seen in that state takes the grant at the next clock edge, so the word appears on `m_cmd_valid`/`m_cmd_data` one cycle after its valid rose.
- R3: If both ports present a command valid while no grant is held, port 0 is granted, and its transaction is accepted in full before any word of port 1.
- R4: A granted port keeps the grant until its transaction ends. A command raised meanwhile by the other port, including port 0, sees its ready held low.
- R5: After the owner's SYNC command (upper four bits = 4'b0011) is accepted by the master port, no further command is forwarded until the transaction ends.
- R6: The transaction ends on a sync response handshake (`m_sync_valid` and `m_sync_ready` high) whose 8-bit data equals the low 8 bits of the accepted SYNC. In the next cycle no grant is held, and a pending request is granted at the edge after that.
- R7: A sync response whose identifier differs from the accepted SYNC is still delivered to the owner but does not end the transaction.
- R8: Transmit data passes only between the owner and the master port. The non-owner's `tx_ready` is low, and with no grant `m_tx_valid` is low.
- R9: Receive data and sync responses go only to the owner, and the non-owner's valid is low. With no grant, both return valids and `m_rx_ready`/`m_sync_ready` are low.
- R10: Command words reach `m_cmd_data` unchanged and in the order each port issued them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous reset, active low |
| p0_cmd_valid | input | 1 | Port 0 command valid |
| p0_cmd_ready | output | 1 | Port 0 command ready |
| p0_cmd_data | input | 16 | Port 0 command word |
| p0_tx_valid | input | 1 | Port 0 transmit data valid |
| p0_tx_ready | output | 1 | Port 0 transmit data ready |
| p0_tx_data | input | 8 | Port 0 transmit data |
| p0_rx_valid | output | 1 | Port 0 receive data valid |
| p0_rx_ready | input | 1 | Port 0 receive data ready |
| p0_rx_data | output | 8 | Port 0 receive data |
| p0_sync_valid | output | 1 | Port 0 sync response valid |
| p0_sync_ready | input | 1 | Port 0 sync response ready |
| p0_sync_data | output | 8 | Port 0 sync response identifier |
| p1_cmd_valid | input | 1 | Port 1 command valid |
| p1_cmd_ready | output | 1 | Port 1 command ready |
| p1_cmd_data | input | 16 | Port 1 command word |
| p1_tx_valid | input | 1 | Port 1 transmit data valid |
| p1_tx_ready | output | 1 | Port 1 transmit data ready |
| p1_tx_data | input | 8 | Port 1 transmit data |
| p1_rx_valid | output | 1 | Port 1 receive data valid |
| p1_rx_ready | input | 1 | Port 1 receive data ready |
| p1_rx_data | output | 8 | Port 1 receive data |
| p1_sync_valid | output | 1 | Port 1 sync response valid |
| p1_sync_ready | input | 1 | Port 1 sync response ready |
| p1_sync_data | output | 8 | Port 1 sync response identifier |
| m_cmd_valid | output | 1 | Command valid toward engine |
| m_cmd_ready | input | 1 | Engine command ready |
| m_cmd_data | output | 16 | Command word toward engine |
| m_tx_valid | output | 1 | Transmit data valid toward engine |
| m_tx_ready | input | 1 | Engine transmit data ready |
| m_tx_data | output | 8 | Transmit data toward engine |
| m_rx_valid | input | 1 | Receive data valid from engine |
| m_rx_ready | output | 1 | Receive data ready toward engine |
| m_rx_data | input | 8 | Receive data from engine |
| m_sync_valid | input | 1 | Sync response valid from engine |
| m_sync_ready | output | 1 | Sync response ready toward engine |
| m_sync_data | input | 8 | Sync response identifier from engine |

## Verification
The properties assume that a generator holds a command valid high until it is accepted, and that the engine answers each accepted SYNC with a response, possibly preceded by stray ones. The priority property relies on port 0's valid being stable across the grant edge.

The bench's senders raise a valid and keep it up until the ready is seen, then drop it just after the edge. The engine model sends one response per SYNC it sees, plus a deliberately wrong identifier when a scenario asks for one. Stimulus never presents a response while no SYNC is outstanding.

// File: rtl/cmd_arb_pkg.sv
package cmd_arb_pkg;
    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_OPEN = 2'd1,
        GS_HOLD = 2'd2
    } gnt_state_e;

    localparam int PORT_CNT = 2;
endpackage

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl
    import cmd_arb_pkg::*;
#(
    parameter int CMD_W = 16,
    parameter int ID_W  = 8,
    parameter int OP_W  = 4,
    parameter logic [OP_W-1:0] SYNC_OP = 4'b0011
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PORT_CNT-1:0] req,
    input  logic [CMD_W-1:0]    cmd_word,
    input  logic                cmd_fire,
    input  logic                rsp_fire,
    input  logic [ID_W-1:0]     rsp_id,
    output logic                gnt_active,
    output logic                gnt_owner,
    output logic                gnt_open,
    output logic                gnt_hold
);
    typedef struct packed {
        gnt_state_e      st;
        logic            own;
        logic [ID_W-1:0] id;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic is_sync;

    always_comb begin
        is_sync = (cmd_word[CMD_W-1 -: OP_W] == SYNC_OP);
        ctl_d   = ctl_q;
        case (ctl_q.st)
            GS_IDLE: begin
                if (|req) begin
                    ctl_d.st  = GS_OPEN;
                    ctl_d.own = ~req[0];
                end
            end
            GS_OPEN: begin
                if (cmd_fire && is_sync) begin
                    ctl_d.st = GS_HOLD;
                    ctl_d.id = cmd_word[ID_W-1:0];
                end
            end
            GS_HOLD: begin
                if (rsp_fire && (rsp_id == ctl_q.id)) begin
                    ctl_d.st = GS_IDLE;
                end
            end
            default: ctl_d.st = GS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: GS_IDLE, own: 1'b0, id: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign gnt_active = (ctl_q.st != GS_IDLE);
    assign gnt_open   = (ctl_q.st == GS_OPEN);
    assign gnt_hold   = (ctl_q.st == GS_HOLD);
    assign gnt_owner  = ctl_q.own;
endmodule

// File: rtl/arb_fwd_path.sv
module arb_fwd_path
    import cmd_arb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                        en,
    input  logic                        sel,
    input  logic [PORT_CNT-1:0]         src_valid,
    input  logic [PORT_CNT-1:0][W-1:0]  src_data,
    output logic [PORT_CNT-1:0]         src_ready,
    output logic                        dst_valid,
    output logic [W-1:0]                dst_data,
    input  logic                        dst_ready
);
    assign dst_valid = en & src_valid[sel];
    assign dst_data  = src_data[sel];

    for (genvar i = 0; i < PORT_CNT; i++) begin : g_rdy
        assign src_ready[i] = en & (sel == i[0]) & dst_ready;
    end
endmodule

// File: rtl/arb_ret_path.sv
module arb_ret_path
    import cmd_arb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                        en,
    input  logic                        sel,
    input  logic                        src_valid,
    input  logic [W-1:0]                src_data,
    output logic                        src_ready,
    output logic [PORT_CNT-1:0]         dst_valid,
    output logic [PORT_CNT-1:0][W-1:0]  dst_data,
    input  logic [PORT_CNT-1:0]         dst_ready
);
    assign src_ready = en & dst_ready[sel];

    for (genvar i = 0; i < PORT_CNT; i++) begin : g_out
        assign dst_valid[i] = en & (sel == i[0]) & src_valid;
        assign dst_data[i]  = src_data;
    end
endmodule

// File: rtl/cmd_stream_arbiter.sv
module cmd_stream_arbiter
    import cmd_arb_pkg::*;
#(
    parameter int CMD_W  = 16,
    parameter int DATA_W = 8,
    parameter int ID_W   = 8,
    parameter int OP_W   = 4,
    parameter logic [OP_W-1:0] SYNC_OP = 4'b0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_cmd_valid,
    output logic              p0_cmd_ready,
    input  logic [CMD_W-1:0]  p0_cmd_data,
    input  logic              p0_tx_valid,
    output logic              p0_tx_ready,
    input  logic [DATA_W-1:0] p0_tx_data,
    output logic              p0_rx_valid,
    input  logic              p0_rx_ready,
    output logic [DATA_W-1:0] p0_rx_data,
    output logic              p0_sync_valid,
    input  logic              p0_sync_ready,
    output logic [ID_W-1:0]   p0_sync_data,
    input  logic              p1_cmd_valid,
    output logic              p1_cmd_ready,
    input  logic [CMD_W-1:0]  p1_cmd_data,
    input  logic              p1_tx_valid,
    output logic              p1_tx_ready,
    input  logic [DATA_W-1:0] p1_tx_data,
    output logic              p1_rx_valid,
    input  logic              p1_rx_ready,
    output logic [DATA_W-1:0] p1_rx_data,
    output logic              p1_sync_valid,
    input  logic              p1_sync_ready,
    output logic [ID_W-1:0]   p1_sync_data,
    output logic              m_cmd_valid,
    input  logic              m_cmd_ready,
    output logic [CMD_W-1:0]  m_cmd_data,
    output logic              m_tx_valid,
    input  logic              m_tx_ready,
    output logic [DATA_W-1:0] m_tx_data,
    input  logic              m_rx_valid,
    output logic              m_rx_ready,
    input  logic [DATA_W-1:0] m_rx_data,
    input  logic              m_sync_valid,
    output logic              m_sync_ready,
    input  logic [ID_W-1:0]   m_sync_data
);
    logic gnt_active, gnt_owner, gnt_open, gnt_hold;

    logic [PORT_CNT-1:0]              cmd_v, cmd_r, tx_v, tx_r;
    logic [PORT_CNT-1:0][CMD_W-1:0]   cmd_d;
    logic [PORT_CNT-1:0][DATA_W-1:0]  tx_d, rx_d;
    logic [PORT_CNT-1:0]              rx_v, rx_r, sy_v, sy_r;
    logic [PORT_CNT-1:0][ID_W-1:0]    sy_d;

    assign cmd_v = {p1_cmd_valid, p0_cmd_valid};
    assign cmd_d = {p1_cmd_data, p0_cmd_data};
    assign tx_v  = {p1_tx_valid, p0_tx_valid};
    assign tx_d  = {p1_tx_data, p0_tx_data};
    assign rx_r  = {p1_rx_ready, p0_rx_ready};
    assign sy_r  = {p1_sync_ready, p0_sync_ready};

    assign p0_cmd_ready  = cmd_r[0];
    assign p1_cmd_ready  = cmd_r[1];
    assign p0_tx_ready   = tx_r[0];
    assign p1_tx_ready   = tx_r[1];
    assign p0_rx_valid   = rx_v[0];
    assign p1_rx_valid   = rx_v[1];
    assign p0_rx_data    = rx_d[0];
    assign p1_rx_data    = rx_d[1];
    assign p0_sync_valid = sy_v[0];
    assign p1_sync_valid = sy_v[1];
    assign p0_sync_data  = sy_d[0];
    assign p1_sync_data  = sy_d[1];

    arb_grant_ctrl #(
        .CMD_W(CMD_W), .ID_W(ID_W), .OP_W(OP_W), .SYNC_OP(SYNC_OP)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (cmd_v),
        .cmd_word   (m_cmd_data),
        .cmd_fire   (m_cmd_valid & m_cmd_ready),
        .rsp_fire   (m_sync_valid & m_sync_ready),
        .rsp_id     (m_sync_data),
        .gnt_active (gnt_active),
        .gnt_owner  (gnt_owner),
        .gnt_open   (gnt_open),
        .gnt_hold   (gnt_hold)
    );

    arb_fwd_path #(.W(CMD_W)) u_cmd (
        .en(gnt_open), .sel(gnt_owner),
        .src_valid(cmd_v), .src_data(cmd_d), .src_ready(cmd_r),
        .dst_valid(m_cmd_valid), .dst_data(m_cmd_data), .dst_ready(m_cmd_ready)
    );

    arb_fwd_path #(.W(DATA_W)) u_tx (
        .en(gnt_active), .sel(gnt_owner),
        .src_valid(tx_v), .src_data(tx_d), .src_ready(tx_r),
        .dst_valid(m_tx_valid), .dst_data(m_tx_data), .dst_ready(m_tx_ready)
    );

    arb_ret_path #(.W(DATA_W)) u_rx (
        .en(gnt_active), .sel(gnt_owner),
        .src_valid(m_rx_valid), .src_data(m_rx_data), .src_ready(m_rx_ready),
        .dst_valid(rx_v), .dst_data(rx_d), .dst_ready(rx_r)
    );

    arb_ret_path #(.W(ID_W)) u_sync (
        .en(gnt_active), .sel(gnt_owner),
        .src_valid(m_sync_valid), .src_data(m_sync_data), .src_ready(m_sync_ready),
        .dst_valid(sy_v), .dst_data(sy_d), .dst_ready(sy_r)
    );
endmodule

// File: rtl/arb_checker.sv
module arb_checker (
    input logic clk,
    input logic rst_n,
    input logic gnt_active,
    input logic gnt_owner,
    input logic gnt_hold,
    input logic p0_cmd_valid,
    input logic p0_cmd_ready,
    input logic p1_cmd_ready,
    input logic p0_tx_ready,
    input logic p1_tx_ready,
    input logic p0_rx_valid,
    input logic p1_rx_valid,
    input logic p0_sync_valid,
    input logic p1_sync_valid,
    input logic m_cmd_valid,
    input logic m_sync_valid,
    input logic m_sync_ready
);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_active |-> (!m_cmd_valid && !p0_cmd_ready && !p1_cmd_ready));

    assert_low_index_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_active && p0_cmd_valid) |=> (gnt_active && !gnt_owner));

    assert_grant_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_active && !(gnt_hold && m_sync_valid && m_sync_ready))
        |=> (gnt_active && (gnt_owner == $past(gnt_owner))));

    assert_single_cmd_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(p0_cmd_ready && p1_cmd_ready));

    assert_no_cmd_after_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_hold |-> !m_cmd_valid);

    assert_single_tx_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(p0_tx_ready && p1_tx_ready));

    assert_return_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(p0_rx_valid && p1_rx_valid) && !(p0_sync_valid && p1_sync_valid));

    assert_sync_to_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_sync_valid || p1_sync_valid) |-> (gnt_active && (p1_sync_valid == gnt_owner)));
endmodule

bind cmd_stream_arbiter arb_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gnt_active   (gnt_active),
    .gnt_owner    (gnt_owner),
    .gnt_hold     (gnt_hold),
    .p0_cmd_valid (p0_cmd_valid),
    .p0_cmd_ready (p0_cmd_ready),
    .p1_cmd_ready (p1_cmd_ready),
    .p0_tx_ready  (p0_tx_ready),
    .p1_tx_ready  (p1_tx_ready),
    .p0_rx_valid  (p0_rx_valid),
    .p1_rx_valid  (p1_rx_valid),
    .p0_sync_valid(p0_sync_valid),
    .p1_sync_valid(p1_sync_valid),
    .m_cmd_valid  (m_cmd_valid),
    .m_sync_valid (m_sync_valid),
    .m_sync_ready (m_sync_ready)
);

// File: tb/sim_cmd_stream_arbiter.sv
module sim_cmd_stream_arbiter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic        p0_cmd_valid, p0_cmd_ready, p1_cmd_valid, p1_cmd_ready;
    logic [15:0] p0_cmd_data, p1_cmd_data, m_cmd_data;
    logic        p0_tx_valid, p0_tx_ready, p1_tx_valid, p1_tx_ready;
    logic [7:0]  p0_tx_data, p1_tx_data, m_tx_data;
    logic        p0_rx_valid, p0_rx_ready, p1_rx_valid, p1_rx_ready;
    logic [7:0]  p0_rx_data, p1_rx_data, m_rx_data;
    logic        p0_sync_valid, p0_sync_ready, p1_sync_valid, p1_sync_ready;
    logic [7:0]  p0_sync_data, p1_sync_data, m_sync_data;
    logic        m_cmd_valid, m_cmd_ready, m_tx_valid, m_tx_ready;
    logic        m_rx_valid, m_rx_ready, m_sync_valid, m_sync_ready;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_stream_arbiter u0 (.*);

    typedef struct {
        int          port;
        logic [15:0] word;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int r5_viol = 0;
    bit eng_pending = 0;
    bit eng_bad = 0;
    int eng_delay = 2;
    int eng_port = 0;
    logic [7:0] eng_id = 8'h00;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_cmd(input int port, input logic [15:0] w, input string tag);
        exp_t e;
        e.port = port;
        e.word = w;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic send(input int port, input logic [15:0] w);
        if (port == 0) begin
            p0_cmd_valid = 1'b1;
            p0_cmd_data  = w;
            do @(negedge clk); while (!p0_cmd_ready);
            @(posedge clk); #1;
            p0_cmd_valid = 1'b0;
        end else begin
            p1_cmd_valid = 1'b1;
            p1_cmd_data  = w;
            do @(negedge clk); while (!p1_cmd_ready);
            @(posedge clk); #1;
            p1_cmd_valid = 1'b0;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || eng_pending) @(posedge clk);
        @(posedge clk); #1;
    endtask

    // Monitor: compares each accepted command against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (eng_pending && m_cmd_valid) r5_viol++;
            if (m_cmd_valid && m_cmd_ready) begin
                int src;
                src = p1_cmd_ready ? 1 : 0;
                if (exp_q.size() == 0) begin
                    check(32'd1, 32'd0, "R10 unexpected command");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({src[15:0], m_cmd_data}, {e.port[15:0], e.word}, e.tag);
                end
                if (m_cmd_data[15:12] == 4'b0011) begin
                    eng_pending = 1'b1;
                    eng_id      = m_cmd_data[7:0];
                    eng_port    = src;
                end
            end
        end
    end

    task automatic sync_beat(input logic [7:0] id, input int port);
        m_sync_valid = 1'b1;
        m_sync_data  = id;
        do @(negedge clk); while (!m_sync_ready);
        if (port == 0) check({p0_sync_valid, p1_sync_valid, p0_sync_data}, {2'b10, id}, "R9 sync to port 0");
        else           check({p0_sync_valid, p1_sync_valid, p1_sync_data}, {2'b01, id}, "R9 sync to port 1");
        @(posedge clk); #1;
        m_sync_valid = 1'b0;
    endtask

    // Engine model: answers each accepted SYNC
    initial begin
        m_sync_valid = 1'b0;
        m_sync_data  = 8'h00;
        forever begin
            @(posedge clk); #1;
            if (eng_pending) begin
                repeat (eng_delay) @(posedge clk);
                #1;
                if (eng_bad) begin
                    eng_bad = 1'b0;
                    sync_beat(eng_id ^ 8'hFF, eng_port);
                    @(negedge clk);
                    @(negedge clk);
                    check({31'd0, m_cmd_valid}, 32'd0, "R7 foreign id keeps grant");
                    @(posedge clk); #1;
                end
                sync_beat(eng_id, eng_port);
                @(negedge clk);
                check({29'd0, m_cmd_valid, p0_cmd_ready, p1_cmd_ready}, 32'd0, "R6 idle after release");
                eng_pending = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        p0_cmd_valid = 1'b1; p0_cmd_data = 16'h1001;
        p1_cmd_valid = 1'b0; p1_cmd_data = 16'h0;
        p0_tx_valid = 1'b0; p0_tx_data = 8'h0; p1_tx_valid = 1'b0; p1_tx_data = 8'h0;
        p0_rx_ready = 1'b1; p1_rx_ready = 1'b1; p0_sync_ready = 1'b1; p1_sync_ready = 1'b1;
        m_cmd_ready = 1'b1; m_tx_ready = 1'b1; m_rx_valid = 1'b0; m_rx_data = 8'h0;

        // R1: reset holds everything quiet even with a request present
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({28'd0, m_cmd_valid, p0_cmd_ready, p1_cmd_ready, m_tx_valid}, 32'd0, "R1 forward side in reset");
        check({26'd0, p0_rx_valid, p1_rx_valid, p0_sync_valid, p1_sync_valid, m_rx_ready, m_sync_ready},
              32'd0, "R1 return side in reset");
        @(posedge clk); #1;
        p0_cmd_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check({29'd0, m_cmd_valid, p0_cmd_ready, p1_cmd_ready}, 32'd0, "R2 idle after reset");
        @(posedge clk); #1;

        // R3: simultaneous requests, port 0 first
        eng_delay = 2;
        expect_cmd(0, 16'h1101, "R3 port 0 wins tie");
        expect_cmd(0, 16'h3005, "R3 port 0 sync");
        expect_cmd(1, 16'h2201, "R3 port 1 after");
        expect_cmd(1, 16'h3006, "R10 port 1 sync");
        fork
            begin send(0, 16'h1101); send(0, 16'h3005); end
            begin send(1, 16'h2201); send(1, 16'h3006); end
        join
        drain();

        // R2/R4: port 1 alone, then port 0 cannot preempt
        expect_cmd(1, 16'h2301, "R2 first word");
        expect_cmd(1, 16'h2302, "R4 no preempt");
        expect_cmd(1, 16'h3007, "R4 sync ends");
        expect_cmd(0, 16'h1401, "R4 port 0 after");
        expect_cmd(0, 16'h3008, "R10 port 0 sync");
        fork
            begin
                p1_cmd_valid = 1'b1; p1_cmd_data = 16'h2301;
                @(negedge clk);
                check({31'd0, m_cmd_valid}, 32'd0, "R2 grant not yet taken");
                @(negedge clk);
                check({30'd0, m_cmd_valid, p1_cmd_ready}, 32'd3, "R2 grant effective next edge");
                @(posedge clk); #1;
                p1_cmd_valid = 1'b0;
                repeat (3) @(posedge clk);
                #1;
                send(1, 16'h2302);
                send(1, 16'h3007);
            end
            begin
                repeat (2) @(posedge clk);
                #1;
                p0_cmd_valid = 1'b1; p0_cmd_data = 16'h1401;
                @(negedge clk);
                check({31'd0, p0_cmd_ready}, 32'd0, "R4 port 0 held off");
                do @(negedge clk); while (!p0_cmd_ready);
                @(posedge clk); #1;
                p0_cmd_valid = 1'b0;
                send(0, 16'h3008);
            end
        join
        drain();

        // R5/R6: owner blocked after its SYNC until the response
        eng_delay = 4;
        r5_viol = 0;
        expect_cmd(1, 16'h3009, "R5 sync accepted");
        expect_cmd(1, 16'h2601, "R6 next transaction");
        expect_cmd(1, 16'h300A, "R10 closing sync");
        send(1, 16'h3009);
        send(1, 16'h2601);
        send(1, 16'h300A);
        drain();
        check(r5_viol, 32'd0, "R5 no command while waiting");

        // R7: mismatched identifier does not release
        eng_delay = 2;
        eng_bad = 1'b1;
        expect_cmd(0, 16'h1A01, "R7 owner word");
        expect_cmd(0, 16'h300C, "R7 owner sync");
        expect_cmd(1, 16'h2A01, "R7 waits for match");
        expect_cmd(1, 16'h300D, "R10 port 1 sync");
        fork
            begin send(0, 16'h1A01); send(0, 16'h300C); end
            begin send(1, 16'h2A01); send(1, 16'h300D); end
        join
        drain();

        // R8/R9: data streams follow port 1's grant
        expect_cmd(1, 16'h2801, "R8 open transaction");
        send(1, 16'h2801);
        p0_tx_valid = 1'b1; p0_tx_data = 8'hA0;
        p1_tx_valid = 1'b1; p1_tx_data = 8'hB1;
        m_rx_valid = 1'b1; m_rx_data = 8'h5A;
        @(negedge clk);
        check({22'd0, m_tx_valid, m_tx_data, p0_tx_ready, p1_tx_ready}, {22'd0, 1'b1, 8'hB1, 2'b01}, "R8 tx from owner");
        check({21'd0, p0_rx_valid, p1_rx_valid, p1_rx_data, m_rx_ready}, {21'd0, 2'b01, 8'h5A, 1'b1}, "R9 rx to owner");
        @(posedge clk); #1;
        p1_rx_ready = 1'b0;
        @(negedge clk);
        check({31'd0, m_rx_ready}, 32'd0, "R9 owner backpressure");
        @(posedge clk); #1;
        p1_rx_ready = 1'b1;
        m_rx_valid = 1'b0;
        expect_cmd(1, 16'h300B, "R10 sync after data");
        send(1, 16'h300B);
        drain();
        m_rx_valid = 1'b1;
        @(negedge clk);
        check({27'd0, m_tx_valid, p0_tx_ready, p1_tx_ready, p0_rx_valid, p1_rx_valid}, 32'd0, "R8 no grant tx quiet");
        check({31'd0, m_rx_ready}, 32'd0, "R9 no grant rx ready low");
        @(posedge clk); #1;
        m_rx_valid = 1'b0;
        p0_tx_valid = 1'b0;
        p1_tx_valid = 1'b0;

        check(exp_q.size(), 32'd0, "R10 scoreboard drained");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule